// File: doc/BRIEF.md
# Cache-Line Burst Writeback Master

This block writes one 256-bit cache line to memory as a four-beat burst on a 64-bit processor-style bus. A writeback buffer hands it a line address and the whole line over a ready/valid request port. The block then drives a one-clock active-low address strobe, the 32-byte-aligned address and a write indication. One clock after the strobe it begins driving the quadwords in ascending order. It moves to the next quadword only on a clock edge where the active-low burst-ready input is sampled low.

When the writeback displaces a line that is being refilled, the requester raises `fill_busy` while the line-fill read is still on the bus. The block accepts the request but holds back its strobe until the first clock edge at which `fill_busy` is sampled low. The writeback burst therefore starts straight after the fill. When the fourth beat has been acknowledged, the block releases the data bus (output-enable low) and pulses `done` for one clock.

Top module: `wbb_master`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block resets: `ads_n` goes to 1, `dq_oe` to 0, `done` to 0, and `req_ready` reads 1 after that edge.
- R2: A request is taken only on an edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from acceptance until the burst completes. While it is 0, `req_valid`, `req_addr` and `req_line` have no effect on the bus outputs.
- R3: If `fill_busy` is 0 at the accepting edge, `ads_n` is 0 for exactly the next clock. During that clock, `bus_addr` equals `req_addr` with bits [4:0] cleared.
- R4: `bus_wr` is 1 from the strobe clock through the clock in which the fourth beat is acknowledged, and it is 0 when the block is idle.
- R5: `dq_oe` rises in the clock right after the strobe clock. `dq` then carries quadword 0, which is `req_line[63:0]`.
- R6: On an edge where `dq_oe` is 1 and `brdy_n` is sampled 0, `dq` moves from quadword k to quadword k+1, where quadword k is `req_line[64k+63:64k]`. On edges where `brdy_n` is 1, `dq` holds its value.
- R7: `brdy_n` is ignored while the data bus is not driven, including during the strobe clock.
- R8: Exactly four acknowledged beats end the burst. After the fourth one, `dq_oe` is 0, `bus_wr` is 0, `done` is 1 for exactly one clock, and `req_ready` is 1.
- R9: While `fill_busy` is sampled 1, a pending request keeps `ads_n` at 1. The strobe then appears in the clock after the first edge at which `fill_busy` is sampled 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered by the writeback buffer |
| req_ready | output | 1 | Block is idle and will take a request |
| req_addr | input | 32 | Line byte address (low 5 bits discarded) |
| req_line | input | 256 | Line data, quadword k in bits [64k+63:64k] |
| fill_busy | input | 1 | A line-fill read is still in progress on the bus |
| ads_n | output | 1 | Active-low address strobe |
| bus_addr | output | 32 | Burst address, aligned to 32 bytes |
| bus_wr | output | 1 | Write cycle indication |
| dq | output | 64 | Write data (0 when not driven) |
| dq_oe | output | 1 | Data bus output enable |
| brdy_n | input | 1 | Active-low burst ready from memory |
| done | output | 1 | One-clock pulse after the last beat |

## Verification
Every result falls due at a fixed count of clock edges after its stimulus:
- The strobe appears one edge after acceptance, or one edge after `fill_busy` is first seen low.
- Data and `dq_oe` appear one edge after the strobe.
- Each quadword advance and the final release with `done` fall on the edge that samples `brdy_n` low.

The bench drives inputs and samples outputs at the falling edge. It therefore checks the exact clock in which each output should have changed. It also checks every wait-state clock to confirm that nothing moved early. The number of wait states is random, and acknowledges, stray requests and fill delays are inserted where they must have no effect.

// File: rtl/wbb_pkg.sv
// Shared definitions for the burst writeback master.
// Assumes a bus whose burst length and width are fixed per instance.
package wbb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // waiting for a request
        ST_HOLD = 2'd1,   // request taken, fill read still running
        ST_ADDR = 2'd2,   // address strobe clock
        ST_DATA = 2'd3    // data beats
    } wbb_state_t;
endpackage

// File: rtl/wbb_line_buf.sv
// Line capture buffer: stores the line and aligned address on load and
// presents the quadword selected by the beat index.
// Assumes load is only asserted while the sequencer is idle.
module wbb_line_buf #(
    parameter int DATA_W = 64,
    parameter int BEATS  = 4,
    parameter int ADDR_W = 32,
    localparam int LINE_W = DATA_W * BEATS,
    localparam int OFF_W  = $clog2(LINE_W / 8),
    localparam int IDX_W  = $clog2(BEATS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [LINE_W-1:0] in_line,
    input  logic [IDX_W-1:0]  beat_idx,
    output logic [ADDR_W-1:0] line_addr,
    output logic [DATA_W-1:0] beat_word
);
    logic [LINE_W-1:0] line_q;
    logic [DATA_W-1:0] words [BEATS];

    // Capture the line and the aligned address when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q    <= '0;
            line_addr <= '0;
        end else if (load) begin
            line_q    <= in_line;
            line_addr <= {in_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        end
    end

    // Split the line into quadwords, lowest first.
    for (genvar g = 0; g < BEATS; g++) begin : g_split
        assign words[g] = line_q[g*DATA_W +: DATA_W];
    end

    // Select the quadword for the current beat.
    always_comb beat_word = words[beat_idx];

    // R3: the captured address never carries line-offset bits.
    assert_addr_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        line_addr[OFF_W-1:0] == '0);
endmodule

// File: rtl/wbb_seq.sv
// Burst sequencer: accepts requests while idle, waits out a fill read,
// issues a one-clock strobe, then counts acknowledged data beats.
// Assumes brdy_n is meaningful only while the data bus is driven.
module wbb_seq #(
    parameter int BEATS = 4,
    localparam int IDX_W = $clog2(BEATS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             fill_busy,
    input  logic             brdy_n,
    output logic             req_ready,
    output logic             load,
    output logic [IDX_W-1:0] beat_idx,
    output logic             ads_n,
    output logic             wr,
    output logic             oe,
    output logic             done
);
    import wbb_pkg::*;

    wbb_state_t state, state_nx;
    logic       last_beat;
    logic       beat_ack;

    assign req_ready = (state == ST_IDLE);
    assign load      = req_ready && req_valid;
    assign beat_ack  = (state == ST_DATA) && !brdy_n;
    assign last_beat = (beat_idx == IDX_W'(BEATS - 1));

    // Choose the next phase of the burst.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (req_valid) state_nx = fill_busy ? ST_HOLD : ST_ADDR;
            ST_HOLD: if (!fill_busy) state_nx = ST_ADDR;
            ST_ADDR: state_nx = ST_DATA;
            ST_DATA: if (beat_ack && last_beat) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // Advance the state, the beat counter and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            beat_idx <= '0;
            done     <= 1'b0;
        end else begin
            state <= state_nx;
            done  <= beat_ack && last_beat;
            if (state == ST_ADDR)  beat_idx <= '0;
            else if (beat_ack)     beat_idx <= beat_idx + 1'b1;
        end
    end

    // Bus control levels decoded from the registered state.
    assign ads_n = (state != ST_ADDR);
    assign oe    = (state == ST_DATA);
    assign wr    = (state == ST_ADDR) || (state == ST_DATA);

    // R3: the strobe lasts one clock.
    assert_strobe_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ads_n |=> ads_n);
    // R5: data is driven right after the strobe.
    assert_data_after_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ads_n |=> oe);
    // R2: no request is taken while a burst is in flight.
    assert_no_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && (oe || !ads_n)));
    // R8: done is a one-clock pulse with the bus released.
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!oe && !wr) ##1 !done);
    // R9: while waiting on the fill, no strobe appears.
    assert_fill_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && fill_busy) |=> ads_n);
    // R4: write indication covers strobe and data clocks.
    assert_wr_cover_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ads_n || oe) |-> wr);
endmodule

// File: rtl/wbb_master.sv
// Top of the burst writeback master: joins the sequencer and the line
// buffer and gates the data bus with the output enable.
// Assumes one requester and a single responding memory.
module wbb_master #(
    parameter int DATA_W = 64,
    parameter int BEATS  = 4,
    parameter int ADDR_W = 32,
    localparam int LINE_W = DATA_W * BEATS,
    localparam int IDX_W  = $clog2(BEATS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LINE_W-1:0] req_line,
    input  logic              fill_busy,
    output logic              ads_n,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_wr,
    output logic [DATA_W-1:0] dq,
    output logic              dq_oe,
    input  logic              brdy_n,
    output logic              done
);
    logic             load;
    logic [IDX_W-1:0] beat_idx;
    logic [DATA_W-1:0] beat_word;

    wbb_seq #(.BEATS(BEATS)) u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .fill_busy(fill_busy),
        .brdy_n(brdy_n), .req_ready(req_ready), .load(load), .beat_idx(beat_idx),
        .ads_n(ads_n), .wr(bus_wr), .oe(dq_oe), .done(done)
    );

    wbb_line_buf #(.DATA_W(DATA_W), .BEATS(BEATS), .ADDR_W(ADDR_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .load(load), .in_addr(req_addr),
        .in_line(req_line), .beat_idx(beat_idx), .line_addr(bus_addr),
        .beat_word(beat_word)
    );

    // Drive data only while the bus is owned.
    assign dq = dq_oe ? beat_word : '0;

    // R6: data holds through wait states.
    assert_hold_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe && brdy_n) |=> (!dq_oe || $stable(dq)));
endmodule

// File: tb/tb_wbb_master.sv
// Self-checking bench: random lines, addresses and wait states plus
// directed fill-delay, stray-acknowledge and stray-request cases.
module tb_wbb_master;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [31:0]  req_addr = '0;
    logic [255:0] req_line = '0;
    logic         fill_busy = 1'b0;
    logic         ads_n;
    logic [31:0]  bus_addr;
    logic         bus_wr;
    logic [63:0]  dq;
    logic         dq_oe;
    logic         brdy_n = 1'b1;
    logic         done;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    wbb_master dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_line(req_line), .fill_busy(fill_busy),
        .ads_n(ads_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .dq(dq),
        .dq_oe(dq_oe), .brdy_n(brdy_n), .done(done)
    );

    function automatic logic [31:0] exp_addr(input logic [31:0] a);
        return {a[31:5], 5'b0};
    endfunction

    function automatic logic [63:0] exp_word(input logic [255:0] l, input int k);
        return l[k*64 +: 64];
    endfunction

    task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One burst: fill_len clocks of fill_busy, random wait states.
    task automatic burst(input logic [31:0] a, input logic [255:0] l,
                         input int fill_len, input int max_wait);
        logic [31:0]  ja;
        logic [255:0] jl;
        ja = ~a;
        jl = ~l;
        chk("R2 ready idle", req_ready, 1);
        req_valid = 1'b1; req_addr = a; req_line = l;
        fill_busy = (fill_len > 0);
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < fill_len; i++) begin
            chk("R9 strobe withheld", ads_n, 1);
            chk("R2 busy", req_ready, 0);
            if (i == fill_len - 1) fill_busy = 1'b0;
            @(negedge clk);
        end
        chk("R3 strobe", ads_n, 0);
        chk("R3 address", bus_addr, exp_addr(a));
        chk("R4 wr at strobe", bus_wr, 1);
        chk("R5 no data at strobe", dq_oe, 0);
        // R7 stray acknowledge and R2 stray request during strobe clock.
        brdy_n = 1'b0;
        req_valid = 1'b1; req_addr = ja; req_line = jl;
        @(negedge clk);
        brdy_n = 1'b1; req_valid = 1'b0;
        chk("R3 strobe one clock", ads_n, 1);
        chk("R5 oe after strobe", dq_oe, 1);
        chk("R7 first word not skipped", dq, exp_word(l, 0));
        for (int b = 0; b < 4; b++) begin
            int w;
            w = $urandom_range(max_wait, 0);
            for (int k = 0; k < w; k++) begin
                @(negedge clk);
                chk("R6 hold in wait", dq, exp_word(l, b));
                chk("R4 wr during data", bus_wr, 1);
            end
            brdy_n = 1'b0;
            @(negedge clk);
            brdy_n = 1'b1;
            if (b < 3) begin
                chk("R6 advance", dq, exp_word(l, b + 1));
                chk("R2 addr unchanged", bus_addr, exp_addr(a));
            end
        end
        chk("R8 oe released", dq_oe, 0);
        chk("R8 wr released", bus_wr, 0);
        chk("R8 done", done, 1);
        chk("R8 ready", req_ready, 1);
    endtask

    initial begin
        logic [255:0] ln;
        int s;
        s = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        chk("R1 ads", ads_n, 1);
        chk("R1 oe", dq_oe, 0);
        chk("R1 done", done, 0);
        chk("R1 ready", req_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        // Directed: no wait states, unaligned address.
        ln = {64'h4444_0000_dddd_0004, 64'h3333_0000_cccc_0003,
              64'h2222_0000_bbbb_0002, 64'h1111_0000_aaaa_0001};
        burst(32'h1234_567f, ln, 0, 0);
        @(negedge clk);
        chk("R8 done one clock", done, 0);
        // Directed: back-to-back right after done, after a 3-clock fill.
        burst(32'h0000_0020, ~ln, 3, 2);
        burst(32'hffff_ffe5, ln ^ {4{64'h0f0f_0f0f_0f0f_0f0f}}, 1, 0);
        @(negedge clk);
        // Random bursts.
        for (int n = 0; n < 40; n++) begin
            ln = {$urandom, $urandom, $urandom, $urandom,
                  $urandom, $urandom, $urandom, $urandom};
            burst($urandom, ln, $urandom_range(3, 0), 4);
            repeat ($urandom_range(2, 0)) @(negedge clk);
        end
        // R1: reset in mid-burst.
        req_valid = 1'b1; req_addr = 32'h40; req_line = ln;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid-burst ads", ads_n, 1);
        chk("R1 mid-burst oe", dq_oe, 0);
        chk("R1 mid-burst ready", req_ready, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule